// File: doc/BRIEF.md
# Port Burst Address Sequencer

This block is the address front end of one port of a synchronous memory. At every rising clock edge it decides where the next access goes. It can take a fresh address from the external bus when the strobe is low. It can step its own burst counter by one, so that a run of consecutive words needs no new address on the bus. It can also force the address back to zero. When none of these is requested, it keeps the address it already has.

The three controls are all active low, and they follow a fixed priority. Clear beats load, and load beats step. The chosen address is registered. The access that starts at an edge uses the new value immediately, so neither a load nor a clear costs an idle cycle. The counter has no chip-select input, so it runs the same way whether or not the port is selected. The counter is as wide as the address bus, and it rolls over from the highest address to zero.

Top module: `port_addr_sequencer`

## Requirements
- R1: While `rst_n` is low, both `acc_addr` and `cnt_value` read zero.
- R2: An edge with `clear_n` low makes `cnt_value` zero after that edge, for any levels of `strobe_n` and `step_n`.
- R3: An edge with `clear_n` high and `strobe_n` low puts the value of `ext_addr` at that edge into `cnt_value` and `acc_addr` after that edge.
- R4: An edge with `clear_n` and `strobe_n` high and `step_n` low raises `cnt_value` by exactly one.
- R5: An edge with all three controls high leaves `cnt_value` unchanged, whatever `ext_addr` carries.
- R6: `step_n` has no effect in an edge where `strobe_n` or `clear_n` is low. A load with `step_n` low gives `ext_addr` exactly, not `ext_addr` plus one.
- R7: A step from the all-ones address gives zero.
- R8: After every edge, `acc_addr` equals `cnt_value`. The access that follows a clear edge therefore goes to zero, and the access that follows a load edge goes to the loaded address.
- R9: A clear adds no dead cycle. A step on the edge right after a clear gives address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| ext_addr | input | AW | Externally supplied address |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| step_n | input | 1 | Active-low burst increment |
| clear_n | input | 1 | Active-low return of the counter to zero |
| acc_addr | output | AW | Registered address presented to the array |
| cnt_value | output | AW | Registered burst counter value |

## Verification
Two requests can meet in one edge: a load or a step with a clear, and a step with a load. The directed part drives every such pair, and all three controls low together. The directed part also places a clear right before a step and a load of all ones right before a step. The random part sets each control low with its own probability, so every overlap occurs many times. Each edge is judged against a bench model that applies clear, then load, then step, and both outputs are compared after every edge.

// File: rtl/pbac_pkg.sv
`timescale 1ns/1ps
package pbac_pkg;
  // Operation chosen for one clock edge; encoding is internal only.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;
endpackage

// File: rtl/pbac_cmd_decode.sv
`timescale 1ns/1ps
module pbac_cmd_decode
  import pbac_pkg::*;
(
  input  logic     strobe_n,
  input  logic     step_n,
  input  logic     clear_n,
  output addr_op_e op
);
  // Fixed priority: clear, then load, then step.
  always_comb begin
    if (!clear_n)       op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!step_n)   op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/pbac_next_calc.sv
`timescale 1ns/1ps
module pbac_next_calc
  import pbac_pkg::*;
#(
  parameter int AW = 16
) (
  input  addr_op_e        op,
  input  logic [AW-1:0]   ext_addr,
  input  logic [AW-1:0]   cur,
  output logic [AW-1:0]   nxt,
  output logic            upd
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    upd = 1'b1;
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext_addr;
      OP_STEP:  nxt = cur + ONE;   // wraps naturally at AW bits
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pbac_state_reg.sv
`timescale 1ns/1ps
module pbac_state_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/port_addr_sequencer.sv
`timescale 1ns/1ps
module port_addr_sequencer
  import pbac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          step_n,
  input  logic          clear_n,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cnt_value
);
  localparam int NREG = 2;  // index 0: burst counter, 1: access address

  addr_op_e        op;
  logic [AW-1:0]   cnt_q;
  logic [AW-1:0]   q_v   [NREG];
  logic [AW-1:0]   nxt_v [NREG];
  logic            upd_v [NREG];

  pbac_cmd_decode u_dec (
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clear_n  (clear_n),
    .op       (op)
  );

  // Counter and access register each get their own next-state path;
  // both advance from the counter value so they stay aligned.
  for (genvar g = 0; g < NREG; g++) begin : g_path
    pbac_next_calc #(.AW(AW)) u_nxt (
      .op       (op),
      .ext_addr (ext_addr),
      .cur      (cnt_q),
      .nxt      (nxt_v[g]),
      .upd      (upd_v[g])
    );
    pbac_state_reg #(.W(AW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (upd_v[g]),
      .d     (nxt_v[g]),
      .q     (q_v[g])
    );
  end

  assign cnt_q     = q_v[0];
  assign cnt_value = q_v[0];
  assign acc_addr  = q_v[1];
endmodule

// File: rtl/port_addr_sequencer_chk.sv
`timescale 1ns/1ps
module port_addr_sequencer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          strobe_n,
  input logic          step_n,
  input logic          clear_n,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] cnt_value
);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (cnt_value == '0 && acc_addr == '0));

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> cnt_value == '0);

  a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !strobe_n) |=> cnt_value == $past(ext_addr));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && !step_n) |=> cnt_value == AW'($past(cnt_value) + AW'(1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && step_n) |=> $stable(cnt_value));

  a_r8_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr == cnt_value);
endmodule

bind port_addr_sequencer port_addr_sequencer_chk #(.AW(AW)) u_chk (.*);

// File: tb/port_addr_sequencer_test.sv
`timescale 1ns/1ps
module port_addr_sequencer_test;
  localparam int AW = 16;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n, step_n, clear_n;
  logic [AW-1:0] acc_addr, cnt_value;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;
  logic [AW-1:0] model;

  always #2.5 clk = ~clk;

  port_addr_sequencer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .clear_n(clear_n), .acc_addr(acc_addr), .cnt_value(cnt_value)
  );

  function automatic logic [AW-1:0] next_model(logic [AW-1:0] cur, logic [AW-1:0] ext,
                                               logic s, logic st, logic c);
    if (!c)       return '0;
    else if (!s)  return ext;
    else if (!st) return cur + AW'(1);
    else          return cur;
  endfunction

  function automatic string tag_of(logic [AW-1:0] cur, logic s, logic st, logic c);
    if (!c)             return "R2";
    else if (!s && !st) return "R6";
    else if (!s)        return "R3";
    else if (!st)       return (cur == TOP) ? "R7" : "R4";
    else                return "R5";
  endfunction

  task automatic check(logic [AW-1:0] act, logic [AW-1:0] exp, string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, samples.
  task automatic apply(logic [AW-1:0] ext, logic s, logic st, logic c, string extra = "");
    string t;
    t = tag_of(model, s, st, c);
    ext_addr = ext; strobe_n = s; step_n = st; clear_n = c;
    model = next_model(model, ext, s, st, c);
    @(negedge clk);
    check(cnt_value, model, (extra != "") ? extra : t);
    check(acc_addr, model, "R8");
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; ext_addr = 16'hBEEF; strobe_n = 1'b0; step_n = 1'b0; clear_n = 1'b1;
    model = '0;
    repeat (3) @(negedge clk);
    check(cnt_value, '0, "R1");
    check(acc_addr, '0, "R1");
    rst_n = 1'b1;

    apply(16'h1234, 1'b0, 1'b1, 1'b1);              // R3 load
    apply(16'hFFFF, 1'b1, 1'b0, 1'b1);              // R4 step
    apply(16'hFFFF, 1'b1, 1'b0, 1'b1);
    apply(16'h0F0F, 1'b1, 1'b1, 1'b1);              // R5 hold, bus ignored
    apply(16'hA5A5, 1'b1, 1'b1, 1'b1);
    apply(16'h4000, 1'b0, 1'b0, 1'b1);              // R6 load with step low
    apply(16'h7777, 1'b0, 1'b0, 1'b0);              // R2 all three low
    apply(16'h7777, 1'b1, 1'b0, 1'b1, "R9");        // step right after clear -> 1
    apply(16'h2222, 1'b1, 1'b0, 1'b0);              // R2 clear with step
    apply(16'h3333, 1'b0, 1'b1, 1'b0);              // R2 clear with load
    apply(TOP,      1'b0, 1'b1, 1'b1);              // R3 load all ones
    apply(16'h0000, 1'b1, 1'b0, 1'b1);              // R7 wrap to zero
    apply(16'h0000, 1'b1, 1'b0, 1'b1);              // R4 continue

    for (int i = 0; i < 3000; i++) begin
      logic s, st, c;
      logic [AW-1:0] e;
      e  = AW'($urandom);
      if (($urandom % 8) == 0) e = TOP - AW'($urandom % 2);
      s  = ($urandom % 4) != 0;
      st = ($urandom % 3) == 0;
      c  = ($urandom % 10) != 0;
      apply(e, s, st, c);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (R1..all): actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule